// File: doc/BRIEF.md
# Double-Buffered PWM Compare Value Unit

This unit keeps two compare values, channel A and channel B, for a PWM timer. Each channel has a shadow copy and an active copy. A processor-side write port changes the values. The timer's counter logic sends two single-cycle pulses: one when the counter reaches zero and one when it reaches the period value. The active values drive the downstream compare and action logic.

Each channel runs in one of two modes:

- **Shadow mode.** Writes land in the shadow copy and set a pending flag. The shadow copy moves to the active copy on a selected counter event, so a new duty value never takes effect in the middle of a PWM period.
- **Immediate mode.** Writes go straight to the active copy.

Channel A also has an 8-bit fine-resolution extension. It is buffered and loaded together with A, but it never changes A's pending flag. A 16-bit control word holds the mode bits and the load-event selects. Reading the control word also returns the two pending flags.

Top module: `pwm_cmp_shadow_unit`

## Requirements
- R1: After synchronous active-low reset, every active value, every shadow value, both pending flags and the control word are zero. Both channels therefore start in shadow mode and load on the zero event.
- R2: Control word layout:
  - Bits 1:0 are A's load select and bits 3:2 are B's load select.
  - Bit 4 is A's mode and bit 6 is B's mode. A value of 1 means immediate mode.
  - Bit 8 is A's pending flag and bit 9 is B's pending flag. Both are read-only, so writes to them are ignored.
  - All other bits read as zero. Writing 16'hFFFF therefore reads back 16'h005F while both flags are clear.
- R3: In shadow mode, a write is stored in the shadow copy. The channel's read port shows it the next cycle, and the channel's pending flag is set. The active value does not change until a load occurs.
- R4: Load select 0 copies shadow to active on a zero pulse. The new active value is visible one clock after the pulse cycle.
- R5: Load select 1 loads on a period pulse. Load select 2 loads on either pulse. Load select 3 never loads. A pulse that does not match the select changes neither the active value nor the flag.
- R6: In immediate mode, a write appears on the active value and on the read port one clock later. The pending flag is not set, and the zero and period pulses have no effect whatever the load select is.
- R7: A load clears the pending flag even when nothing was written since the previous load. In that case the active value receives the unchanged shadow value.
- R8: A second write before a load replaces the pending shadow value, and only the newest value is loaded.
- R9: When a write and a load fall in the same cycle, the active value receives the previous shadow value. The new value stays pending in the shadow copy and the flag stays set.
- R10: A write to A's fine-resolution extension alone leaves A's pending flag unchanged. The extension is loaded into its active copy on A's load events in shadow mode, and it is written directly in immediate mode.
- R11: The two channels are independent. A write or load on one channel never changes the other channel's active value or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback, including the pending flags |
| cmpa_wr | input | 1 | Channel A compare write enable |
| cmpa_wdata | input | 16 | Channel A compare write data |
| cmpa_hr_wr | input | 1 | Channel A fine-resolution extension write enable |
| cmpa_hr_wdata | input | 8 | Channel A fine-resolution extension write data |
| cmpb_wr | input | 1 | Channel B compare write enable |
| cmpb_wdata | input | 16 | Channel B compare write data |
| ctr_zero | input | 1 | Single-cycle pulse: counter equals zero |
| ctr_prd | input | 1 | Single-cycle pulse: counter equals period |
| cmpa_active | output | 16 | Channel A active compare value |
| cmpa_hr_active | output | 8 | Channel A active fine-resolution extension |
| cmpb_active | output | 16 | Channel B active compare value |
| cmpa_rdata | output | 16 | Channel A read port: shadow value in shadow mode, active value in immediate mode |
| cmpb_rdata | output | 16 | Channel B read port: shadow value in shadow mode, active value in immediate mode |

## Verification
A processor write to a channel and that channel's load strobe can fall in the same clock cycle. The bench provokes this by asserting a compare write and the zero pulse on the same edge while a value is already pending. The active value must show the older pending value. The read port must show the newer value, and the flag must stay set. A following zero pulse must then deliver the newer value and clear the flag. A sweep over every load select, both event pulses and both channels checks the loading rule. It also confirms that the idle channel stays untouched.

// File: rtl/pwm_cmp_pkg.sv
// Package: shared types and control word field positions for the
// double-buffered PWM compare unit.
// Assumes: control word is at least 10 bits wide.
package pwm_cmp_pkg;

    // Load event select per channel; encoding is visible to software.
    typedef enum logic [1:0] {
        LD_ON_ZERO   = 2'd0,
        LD_ON_PRD    = 2'd1,
        LD_ON_EITHER = 2'd2,
        LD_FROZEN    = 2'd3
    } load_sel_e;

    localparam int SEL_A_LSB  = 0;
    localparam int SEL_B_LSB  = 2;
    localparam int MODE_A_BIT = 4;
    localparam int MODE_B_BIT = 6;
    localparam int FULL_A_BIT = 8;
    localparam int FULL_B_BIT = 9;
    localparam int NUM_CH     = 2;

endpackage

// File: rtl/pwm_cmp_ctl.sv
// Module: pwm_cmp_ctl
// Holds the writable control fields (mode bits and load selects) and
// assembles the readback word together with the pending flags.
// Assumes: REG_W >= 10; pending flags come from the channel logic.
module pwm_cmp_ctl
    import pwm_cmp_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             full_a,
    input  logic             full_b,
    output logic             imm_a,
    output logic             imm_b,
    output load_sel_e        sel_a,
    output load_sel_e        sel_b,
    output logic [REG_W-1:0] ctl_rdata
);

    // Capture mode and load select fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_a <= 1'b0;
            imm_b <= 1'b0;
            sel_a <= LD_ON_ZERO;
            sel_b <= LD_ON_ZERO;
        end else if (cfg_wr) begin
            imm_a <= cfg_wdata[MODE_A_BIT];
            imm_b <= cfg_wdata[MODE_B_BIT];
            sel_a <= load_sel_e'(cfg_wdata[SEL_A_LSB +: 2]);
            sel_b <= load_sel_e'(cfg_wdata[SEL_B_LSB +: 2]);
        end
    end

    // Build readback word; unlisted bits read zero.
    always_comb begin
        ctl_rdata                     = '0;
        ctl_rdata[SEL_A_LSB +: 2]     = sel_a;
        ctl_rdata[SEL_B_LSB +: 2]     = sel_b;
        ctl_rdata[MODE_A_BIT]         = imm_a;
        ctl_rdata[MODE_B_BIT]         = imm_b;
        ctl_rdata[FULL_A_BIT]         = full_a;
        ctl_rdata[FULL_B_BIT]         = full_b;
    end

    // R2
    cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (imm_a == $past(cfg_wdata[MODE_A_BIT]))
                && (sel_b == load_sel_e'($past(cfg_wdata[SEL_B_LSB +: 2]))));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(imm_a) && $stable(imm_b) && $stable(sel_a) && $stable(sel_b));

endmodule

// File: rtl/pwm_cmp_load_sel.sv
// Module: pwm_cmp_load_sel
// Turns the counter event pulses into one channel's load strobe
// according to its load select; no strobe in immediate mode.
// Assumes: zero_hit and prd_hit are single-cycle synchronous pulses.
module pwm_cmp_load_sel
    import pwm_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      imm,
    input  load_sel_e sel,
    input  logic      zero_hit,
    input  logic      prd_hit,
    output logic      strobe
);

    // Decode the selected event into a load strobe.
    always_comb begin
        strobe = 1'b0;
        if (!imm) begin
            unique case (sel)
                LD_ON_ZERO:   strobe = zero_hit;
                LD_ON_PRD:    strobe = prd_hit;
                LD_ON_EITHER: strobe = zero_hit | prd_hit;
                LD_FROZEN:    strobe = 1'b0;
                default:      strobe = 1'b0;
            endcase
        end
    end

    // R6
    imm_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm |-> !strobe);

    // R5
    frozen_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == LD_FROZEN) |-> !strobe);

    // R5
    strobe_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (zero_hit || prd_hit));

endmodule

// File: rtl/pwm_cmp_channel.sv
// Module: pwm_cmp_channel
// One compare channel: shadow and active copies, pending flag and an
// optional fine-resolution extension that follows the same loads.
// Assumes: strobe is already gated off in immediate mode.
module pwm_cmp_channel #(
    parameter int CMP_W  = 16,
    parameter int HR_W   = 8,
    parameter bit HAS_HR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imm,
    input  logic             strobe,
    input  logic             wr,
    input  logic [CMP_W-1:0] wdata,
    input  logic             hr_wr,
    input  logic [HR_W-1:0]  hr_wdata,
    output logic [CMP_W-1:0] active,
    output logic [HR_W-1:0]  hr_active,
    output logic [CMP_W-1:0] rdata,
    output logic             full
);

    logic [CMP_W-1:0] shadow;
    logic [HR_W-1:0]  hr_shadow;

    // Main value: direct write in immediate mode, else shadow plus load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
            full   <= 1'b0;
        end else if (imm) begin
            if (wr) active <= wdata;
        end else begin
            if (strobe) begin
                active <= shadow;
                full   <= 1'b0;
            end
            if (wr) begin
                shadow <= wdata;
                full   <= 1'b1;
            end
        end
    end

    generate
        if (HAS_HR) begin : g_hr
            // Extension follows the main loads but never touches the flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hr_shadow <= '0;
                    hr_active <= '0;
                end else if (imm) begin
                    if (hr_wr) hr_active <= hr_wdata;
                end else begin
                    if (strobe) hr_active <= hr_shadow;
                    if (hr_wr)  hr_shadow <= hr_wdata;
                end
            end
        end else begin : g_no_hr
            logic unused_hr_in;
            assign unused_hr_in = ^{hr_wr, hr_wdata};
            assign hr_shadow    = '0;
            assign hr_active    = '0;
        end
    endgenerate

    // Read port returns what a write would have reached.
    assign rdata = imm ? active : shadow;

    // R3
    shadow_write_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && wr) |=> full);

    // R7
    strobe_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && strobe && !wr) |=> !full);

    // R9
    strobe_moves_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && strobe) |=> (active == $past(shadow)));

    // R6
    imm_write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm && wr) |=> (active == $past(wdata)));

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !strobe) |=> $stable(active));

    // R10
    hr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_wr && !wr && !strobe) |=> $stable(full));

endmodule

// File: rtl/pwm_cmp_shadow_unit.sv
// Module: pwm_cmp_shadow_unit (top)
// Two compare channels with per-channel shadow/immediate mode and load
// event select, a control word, and an extension on channel A only.
// Assumes: ctr_zero/ctr_prd are single-cycle pulses on clk.
module pwm_cmp_shadow_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int HR_W  = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             cmpa_wr,
    input  logic [CMP_W-1:0] cmpa_wdata,
    input  logic             cmpa_hr_wr,
    input  logic [HR_W-1:0]  cmpa_hr_wdata,
    input  logic             cmpb_wr,
    input  logic [CMP_W-1:0] cmpb_wdata,
    input  logic             ctr_zero,
    input  logic             ctr_prd,
    output logic [CMP_W-1:0] cmpa_active,
    output logic [HR_W-1:0]  cmpa_hr_active,
    output logic [CMP_W-1:0] cmpb_active,
    output logic [CMP_W-1:0] cmpa_rdata,
    output logic [CMP_W-1:0] cmpb_rdata
);

    logic             ch_imm    [NUM_CH];
    load_sel_e        ch_sel    [NUM_CH];
    logic             ch_strobe [NUM_CH];
    logic             ch_wr     [NUM_CH];
    logic [CMP_W-1:0] ch_wdata  [NUM_CH];
    logic             ch_hr_wr  [NUM_CH];
    logic [HR_W-1:0]  ch_hr_wd  [NUM_CH];
    logic [CMP_W-1:0] ch_active [NUM_CH];
    logic [HR_W-1:0]  ch_hr_act [NUM_CH];
    logic [CMP_W-1:0] ch_rdata  [NUM_CH];
    logic             ch_full   [NUM_CH];
    logic             unused_hr_b;

    // Route per-channel write inputs; B has no extension.
    assign ch_wr[0]    = cmpa_wr;
    assign ch_wdata[0] = cmpa_wdata;
    assign ch_hr_wr[0] = cmpa_hr_wr;
    assign ch_hr_wd[0] = cmpa_hr_wdata;
    assign ch_wr[1]    = cmpb_wr;
    assign ch_wdata[1] = cmpb_wdata;
    assign ch_hr_wr[1] = 1'b0;
    assign ch_hr_wd[1] = '0;

    pwm_cmp_ctl #(.REG_W(REG_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .full_a    (ch_full[0]),
        .full_b    (ch_full[1]),
        .imm_a     (ch_imm[0]),
        .imm_b     (ch_imm[1]),
        .sel_a     (ch_sel[0]),
        .sel_b     (ch_sel[1]),
        .ctl_rdata (ctl_rdata)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pwm_cmp_load_sel u_lsel (
                .clk      (clk),
                .rst_n    (rst_n),
                .imm      (ch_imm[c]),
                .sel      (ch_sel[c]),
                .zero_hit (ctr_zero),
                .prd_hit  (ctr_prd),
                .strobe   (ch_strobe[c])
            );

            pwm_cmp_channel #(
                .CMP_W  (CMP_W),
                .HR_W   (HR_W),
                .HAS_HR (c == 0)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .imm       (ch_imm[c]),
                .strobe    (ch_strobe[c]),
                .wr        (ch_wr[c]),
                .wdata     (ch_wdata[c]),
                .hr_wr     (ch_hr_wr[c]),
                .hr_wdata  (ch_hr_wd[c]),
                .active    (ch_active[c]),
                .hr_active (ch_hr_act[c]),
                .rdata     (ch_rdata[c]),
                .full      (ch_full[c])
            );
        end
    endgenerate

    assign cmpa_active    = ch_active[0];
    assign cmpa_hr_active = ch_hr_act[0];
    assign cmpb_active    = ch_active[1];
    assign cmpa_rdata     = ch_rdata[0];
    assign cmpb_rdata     = ch_rdata[1];
    assign unused_hr_b    = ^ch_hr_act[1];

    // R11
    b_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpb_wr && !ch_strobe[1]) |=> $stable(cmpb_active));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_rdata == '0) && (cmpa_active == '0) && (cmpb_active == '0));

endmodule

// File: tb/pwm_cmp_shadow_unit_tb.sv
// Bench: sweeps every load select and event on both channels, then the
// immediate mode, overwrite, collision and extension cases.
module pwm_cmp_shadow_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        cmpa_wr = 1'b0;
    logic [15:0] cmpa_wdata = '0;
    logic        cmpa_hr_wr = 1'b0;
    logic [7:0]  cmpa_hr_wdata = '0;
    logic        cmpb_wr = 1'b0;
    logic [15:0] cmpb_wdata = '0;
    logic        ctr_zero = 1'b0;
    logic        ctr_prd = 1'b0;
    logic [15:0] cmpa_active, cmpb_active, cmpa_rdata, cmpb_rdata;
    logic [7:0]  cmpa_hr_active;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_act [2];

    always #5 clk = ~clk;

    pwm_cmp_shadow_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctl_rdata(ctl_rdata), .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
        .cmpa_hr_wr(cmpa_hr_wr), .cmpa_hr_wdata(cmpa_hr_wdata),
        .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata), .ctr_zero(ctr_zero),
        .ctr_prd(ctr_prd), .cmpa_active(cmpa_active),
        .cmpa_hr_active(cmpa_hr_active), .cmpb_active(cmpb_active),
        .cmpa_rdata(cmpa_rdata), .cmpb_rdata(cmpb_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] act_of(input int ch);
        return (ch == 0) ? cmpa_active : cmpb_active;
    endfunction

    function automatic logic flag_of(input int ch);
        return ctl_rdata[8 + ch];
    endfunction

    task automatic set_ctl(input logic [15:0] v);
        cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_ch(input int ch, input logic [15:0] v);
        if (ch == 0) begin cmpa_wdata = v; cmpa_wr = 1'b1; end
        else         begin cmpb_wdata = v; cmpb_wr = 1'b1; end
        @(negedge clk);
        cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    endtask

    task automatic pulse(input logic z, input logic p);
        ctr_zero = z; ctr_prd = p;
        @(negedge clk);
        ctr_zero = 1'b0; ctr_prd = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 16'h0000);
        chk("R1 actA", cmpa_active, 0);
        chk("R1 actB", cmpb_active, 0);
        chk("R1 hr", cmpa_hr_active, 0);
        exp_act[0] = '0; exp_act[1] = '0;

        // R2 layout: reserved and flag bits read zero
        set_ctl(16'hFFFF);
        chk("R2 readback", ctl_rdata, 16'h005F);
        set_ctl(16'h0000);
        chk("R2 cleared", ctl_rdata, 16'h0000);

        // R3 R4 R5 R11 sweep over channel, select and event
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int ev = 0; ev < 2; ev++) begin
                    logic [15:0] v;
                    logic ld;
                    v  = 16'h1000 + 16'(ch * 256 + sel * 16 + ev);
                    ld = (sel == 0 && ev == 0) || (sel == 1 && ev == 1) || (sel == 2);
                    set_ctl(16'(sel << (ch * 2)));
                    wr_ch(ch, v);
                    chk("R3 flag set", flag_of(ch), 1);
                    chk("R3 active held", act_of(ch), exp_act[ch]);
                    chk("R3 rdata shadow", (ch == 0) ? cmpa_rdata : cmpb_rdata, v);
                    pulse(ev == 0, ev == 1);
                    if (ld) exp_act[ch] = v;
                    chk(sel == 0 ? "R4 load" : "R5 load", act_of(ch), exp_act[ch]);
                    chk(sel == 0 ? "R4 flag" : "R5 flag", flag_of(ch), !ld);
                    chk("R11 other active", act_of(1 - ch), exp_act[1 - ch]);
                    chk("R11 other flag", flag_of(1 - ch), 0);
                    set_ctl(16'h0000);
                    pulse(1'b1, 1'b0);
                    exp_act[ch] = v;
                    chk("R4 drain", act_of(ch), v);
                end
            end
        end

        // R6 immediate mode on both channels, freeze select ignored
        set_ctl(16'h005F);
        wr_ch(0, 16'hABCD);
        chk("R6 direct A", cmpa_active, 16'hABCD);
        chk("R6 rdata A", cmpa_rdata, 16'hABCD);
        chk("R6 no flag", flag_of(0), 0);
        wr_ch(1, 16'h5678);
        chk("R6 direct B", cmpb_active, 16'h5678);
        set_ctl(16'h0050);
        pulse(1'b1, 1'b1);
        chk("R6 pulse ignored A", cmpa_active, 16'hABCD);
        chk("R6 pulse ignored B", cmpb_active, 16'h5678);
        set_ctl(16'h0000);

        // R7 load without new write keeps value, flag clear
        wr_ch(0, 16'h0777);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R7 active", cmpa_active, 16'h0777);
        chk("R7 flag", flag_of(0), 0);

        // R8 overwrite, and R2 flag is read-only
        wr_ch(0, 16'h1111);
        wr_ch(0, 16'h2222);
        set_ctl(16'h0000);
        chk("R2 flag read-only", flag_of(0), 1);
        pulse(1'b1, 1'b0);
        chk("R8 newest", cmpa_active, 16'h2222);

        // R9 write and load in the same cycle
        wr_ch(0, 16'h3333);
        cmpa_wdata = 16'h4444; cmpa_wr = 1'b1; ctr_zero = 1'b1;
        @(negedge clk);
        cmpa_wr = 1'b0; ctr_zero = 1'b0;
        chk("R9 old loaded", cmpa_active, 16'h3333);
        chk("R9 flag kept", flag_of(0), 1);
        chk("R9 new pending", cmpa_rdata, 16'h4444);
        pulse(1'b1, 1'b0);
        chk("R9 new loaded", cmpa_active, 16'h4444);
        chk("R9 flag clear", flag_of(0), 0);

        // R10 extension
        cmpa_hr_wdata = 8'h5A; cmpa_hr_wr = 1'b1;
        @(negedge clk);
        cmpa_hr_wr = 1'b0;
        chk("R10 flag untouched", flag_of(0), 0);
        chk("R10 hr held", cmpa_hr_active, 8'h00);
        pulse(1'b1, 1'b0);
        chk("R10 hr loaded", cmpa_hr_active, 8'h5A);
        set_ctl(16'h0010);
        cmpa_hr_wdata = 8'h77; cmpa_hr_wr = 1'b1;
        @(negedge clk);
        cmpa_hr_wr = 1'b0;
        chk("R10 hr immediate", cmpa_hr_active, 8'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule